// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a system watchdog with a small register bank on a byte-addressed, 16-bit wide bus. A prescaler divides the core clock into a slow tick. Each tick decrements a 10-bit countdown. The countdown is loaded from a timer-initial-value register. Firmware keeps the system alive by writing the reload register before the countdown runs out.

The first expiry does three things: it sets a timeout flag, can pulse the system-management interrupt output, and restarts the countdown. A second expiry with no reload in between sets the second-timeout and boot status bits. It then pulses a reboot request and halts the countdown. Two inputs can block that reboot: a speaker-pin strap and a no-reboot control. When either is high, the second expiry behaves like a first one. The bank also holds the following:
- a data-in register, whose write raises a status flag and an unconditional interrupt pulse;
- a data-out register, whose write raises a status flag;
- message and scratch registers;
- a halt control;
- a lock bit that software can set but never clear.

Top module: `wdog_top`

## Requirements
- R1: After reset the bank reads as follows: timer-initial-value (0x12) = 0x0004, control2 (0x0A) = 0x0008, software-IRQ (0x10) = 0x03. Reload (0x00), status1 (0x04), status2 (0x06) and control1 (0x08) read 0. The countdown is idle and neither output pulses.
- R2: The countdown runs only while control1 bit 11 (halt) is 0 and timer-initial-value is greater than 1. A value of 0 or 1 never starts it. Writing halt = 1 stops it.
- R3: Any write to reload (0x00) clears the consecutive-expiry count. If the countdown may run, the write loads it from timer-initial-value bits 9:0 and starts it. Otherwise the written value is stored and reads back unchanged.
- R4: An expiry occurs exactly N×TICK_CYCLES clock cycles after a load, where N is the loaded count. It sets status1 bit 3, and the countdown reloads and keeps running.
- R5: If a second expiry follows with no reload write, status2 bits 1 and 2 are set. When the strap and no-reboot inputs are both low, reboot_pulse is high for one cycle, the countdown stops, and reload reads 0.
- R6: If strap or no-reboot is high at a second expiry, the second expiry still sets status2 bits 1 and 2. It then acts like a first expiry, and the expiry after it counts as a first one again.
- R7: A write to data-in (0x02) stores the byte, sets status1 bit 1 and pulses smi_pulse whatever smi_en is. A write to data-out (0x03) stores the byte and sets status1 bit 2.
- R8: Control1 writes are masked with 0xFEFF. Software can set bit 12 (lock), but only reset clears it.
- R9: A write to status1 stores the value masked with 0xE870. A write to status2 stores the value masked with 0xFFF8.
- R10: While the countdown runs, reload bits 9:0 read the ticks remaining.
- R11: An expiry that does not reboot pulses smi_pulse for one cycle only when smi_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data (8-bit registers use bits 7:0) |
| bus_rdata | output | 16 | Read data for bus_addr, same cycle |
| strap_hi | input | 1 | Strap; high blocks the reboot |
| no_reboot | input | 1 | High blocks the reboot |
| smi_en | input | 1 | Enables the interrupt pulse on expiry |
| smi_pulse | output | 1 | One-cycle system-management interrupt |
| reboot_pulse | output | 1 | One-cycle reboot request |

## Verification
The bench targets the consecutive-expiry count. It lets one expiry pass, then reloads, then checks that the next expiry only raises an interrupt. A design that failed to clear the count would reboot one period too early. A blocked second expiry must rearm the sequence; a design that failed to restart it would reboot on the third expiry or raise no interrupt at all. Further checks cover:
- the refused initial values 0 and 1, where a faulty design would start counting and pulse unexpectedly;
- the lock bit, which a naive masked write would clear;
- the exact expiry cycle, which a prescaler that is not restarted on a load would miss by up to one tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   timeunit 1ns; timeprecision 100ps;

   localparam int ADDR_W = 5;

   // register byte offsets
   localparam logic [ADDR_W-1:0] ADR_RELOAD = 5'h00;
   localparam logic [ADDR_W-1:0] ADR_DIN    = 5'h02;
   localparam logic [ADDR_W-1:0] ADR_DOUT   = 5'h03;
   localparam logic [ADDR_W-1:0] ADR_STS1   = 5'h04;
   localparam logic [ADDR_W-1:0] ADR_STS2   = 5'h06;
   localparam logic [ADDR_W-1:0] ADR_CTL1   = 5'h08;
   localparam logic [ADDR_W-1:0] ADR_CTL2   = 5'h0A;
   localparam logic [ADDR_W-1:0] ADR_MSGA   = 5'h0C;
   localparam logic [ADDR_W-1:0] ADR_MSGB   = 5'h0D;
   localparam logic [ADDR_W-1:0] ADR_WDCNT  = 5'h0E;
   localparam logic [ADDR_W-1:0] ADR_SWIRQ  = 5'h10;
   localparam logic [ADDR_W-1:0] ADR_INIT   = 5'h12;

   // write masks
   localparam logic [15:0] CTL1_WMASK = 16'hFEFF;
   localparam logic [15:0] STS1_WMASK = 16'hE870;
   localparam logic [15:0] STS2_WMASK = 16'hFFF8;

   // bit positions
   localparam int HALT_BIT   = 11;
   localparam int LOCK_BIT   = 12;
   localparam int TMO_BIT    = 3;
   localparam int DIN_BIT    = 1;
   localparam int DOUT_BIT   = 2;
   localparam int SECOND_BIT = 1;
   localparam int BOOT_BIT   = 2;

   // reset values
   localparam logic [15:0] INIT_RST  = 16'h0004;
   localparam logic [15:0] CTL2_RST  = 16'h0008;
   localparam logic [7:0]  SWIRQ_RST = 8'h03;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int TICK_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   timeunit 1ns; timeprecision 100ps;

   localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("wdog_prescale: TICK_CYCLES must be at least 1");
   end

   logic [PW-1:0] pre_q;

   assign tick = (pre_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (restart || tick)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic             stop,
   input  logic [CNT_W-1:0] load_val,
   output logic             run,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   timeunit 1ns; timeprecision 100ps;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2 || CNT_W > 15) begin : g_bad_width
      $error("wdog_counter: CNT_W must lie in 2..15");
   end

   assign expire = run && tick && (count <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         count <= '0;
      end else if (stop) begin
         run   <= 1'b0;
      end else if (load) begin
         run   <= 1'b1;
         count <= load_val;
      end else if (run && tick) begin
         count <= count - ONE;
      end
   end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic              strap_hi,
   input  logic              no_reboot,
   input  logic              smi_en,
   input  logic              expire,
   input  logic              run,
   input  logic [CNT_W-1:0]  count,
   output logic              load,
   output logic              stop,
   output logic [CNT_W-1:0]  load_val,
   output logic              smi_pulse,
   output logic              reboot_pulse,
   output logic              lock,
   output logic [15:0]       tmr_val,
   output logic [15:0]       sts2_val
);
   timeunit 1ns; timeprecision 100ps;

   logic [15:0] rld_q, sts1_q, sts2_q, ctl1_q, ctl2_q, tmr_q;
   logic [7:0]  din_q, dout_q, msga_q, msgb_q, wdcnt_q, swirq_q;
   logic        armed_q, smi_q, reboot_q;

   logic        wr, hit_rld, hit_ctl1, hit_din;
   logic        may_run, ctl1_may_run, do_reboot;
   logic [15:0] ctl1_next;

   assign wr       = bus_sel && bus_wr;
   assign hit_rld  = wr && (bus_addr == ADR_RELOAD);
   assign hit_ctl1 = wr && (bus_addr == ADR_CTL1);
   assign hit_din  = wr && (bus_addr == ADR_DIN);

   assign ctl1_next    = (bus_wdata & CTL1_WMASK) | (ctl1_q & (16'h1 << LOCK_BIT));
   assign may_run      = !ctl1_q[HALT_BIT] && (tmr_q > 16'd1);
   assign ctl1_may_run = !ctl1_next[HALT_BIT] && (tmr_q > 16'd1);
   assign do_reboot    = expire && armed_q && !strap_hi && !no_reboot;

   // countdown control
   assign load = (expire && !do_reboot) || (hit_rld && may_run) || (hit_ctl1 && ctl1_may_run);
   assign stop = do_reboot || (hit_ctl1 && !ctl1_may_run);
   assign load_val = tmr_q[CNT_W-1:0];

   assign smi_pulse    = smi_q;
   assign reboot_pulse = reboot_q;
   assign lock         = ctl1_q[LOCK_BIT];
   assign tmr_val      = tmr_q;
   assign sts2_val     = sts2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_q    <= '0;
         sts1_q   <= '0;
         sts2_q   <= '0;
         ctl1_q   <= '0;
         ctl2_q   <= CTL2_RST;
         tmr_q    <= INIT_RST;
         din_q    <= '0;
         dout_q   <= '0;
         msga_q   <= '0;
         msgb_q   <= '0;
         wdcnt_q  <= '0;
         swirq_q  <= SWIRQ_RST;
         armed_q  <= 1'b0;
         smi_q    <= 1'b0;
         reboot_q <= 1'b0;
      end else begin
         smi_q    <= (expire && !do_reboot && smi_en) || hit_din;
         reboot_q <= do_reboot;

         if (expire) begin
            sts1_q[TMO_BIT] <= 1'b1;
            if (armed_q) begin
               sts2_q[SECOND_BIT] <= 1'b1;
               sts2_q[BOOT_BIT]   <= 1'b1;
               armed_q            <= 1'b0;
            end else begin
               armed_q <= 1'b1;
            end
            rld_q <= do_reboot ? 16'h0000 : tmr_q;
         end

         if (wr) begin
            case (bus_addr)
               ADR_RELOAD: begin
                  armed_q <= 1'b0;
                  rld_q   <= may_run ? tmr_q : bus_wdata;
               end
               ADR_DIN: begin
                  din_q           <= bus_wdata[7:0];
                  sts1_q[DIN_BIT] <= 1'b1;
               end
               ADR_DOUT: begin
                  dout_q           <= bus_wdata[7:0];
                  sts1_q[DOUT_BIT] <= 1'b1;
               end
               ADR_STS1:  sts1_q  <= bus_wdata & STS1_WMASK;
               ADR_STS2:  sts2_q  <= bus_wdata & STS2_WMASK;
               ADR_CTL1: begin
                  ctl1_q <= ctl1_next;
                  if (ctl1_may_run) rld_q <= tmr_q;
               end
               ADR_CTL2:  ctl2_q  <= bus_wdata;
               ADR_MSGA:  msga_q  <= bus_wdata[7:0];
               ADR_MSGB:  msgb_q  <= bus_wdata[7:0];
               ADR_WDCNT: wdcnt_q <= bus_wdata[7:0];
               ADR_SWIRQ: swirq_q <= bus_wdata[7:0];
               ADR_INIT:  tmr_q   <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (bus_addr)
         ADR_RELOAD: bus_rdata = run ? {rld_q[15:CNT_W], count} : rld_q;
         ADR_DIN:    bus_rdata = {8'h00, din_q};
         ADR_DOUT:   bus_rdata = {8'h00, dout_q};
         ADR_STS1:   bus_rdata = sts1_q;
         ADR_STS2:   bus_rdata = sts2_q;
         ADR_CTL1:   bus_rdata = ctl1_q;
         ADR_CTL2:   bus_rdata = ctl2_q;
         ADR_MSGA:   bus_rdata = {8'h00, msga_q};
         ADR_MSGB:   bus_rdata = {8'h00, msgb_q};
         ADR_WDCNT:  bus_rdata = {8'h00, wdcnt_q};
         ADR_SWIRQ:  bus_rdata = {8'h00, swirq_q};
         ADR_INIT:   bus_rdata = tmr_q;
         default:    bus_rdata = 16'h0000;
      endcase
   end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
   import wdog_pkg::*;
#(
   parameter int TICK_CYCLES = 15_000_000,
   parameter int CNT_W       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic              strap_hi,
   input  logic              no_reboot,
   input  logic              smi_en,
   output logic              smi_pulse,
   output logic              reboot_pulse
);
   timeunit 1ns; timeprecision 100ps;

   logic             tick_w, load_w, stop_w, expire_w, run_w, lock_w;
   logic [CNT_W-1:0] count_w, load_val_w;
   logic [15:0]      tmr_w, sts2_w;

   wdog_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(load_w), .tick(tick_w)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .load(load_w), .stop(stop_w),
      .load_val(load_val_w), .run(run_w), .count(count_w), .expire(expire_w)
   );

   wdog_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .strap_hi(strap_hi), .no_reboot(no_reboot), .smi_en(smi_en),
      .expire(expire_w), .run(run_w), .count(count_w),
      .load(load_w), .stop(stop_w), .load_val(load_val_w),
      .smi_pulse(smi_pulse), .reboot_pulse(reboot_pulse),
      .lock(lock_w), .tmr_val(tmr_w), .sts2_val(sts2_w)
   );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        strap_hi,
   input logic        no_reboot,
   input logic        reboot_pulse,
   input logic        run,
   input logic        lock,
   input logic [15:0] tmr,
   input logic [15:0] sts2
);
   timeunit 1ns; timeprecision 100ps;

   AST_REBOOT_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      reboot_pulse |-> $past(!strap_hi && !no_reboot)); // R5
   AST_REBOOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      reboot_pulse |-> !run); // R5
   AST_REBOOT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      reboot_pulse |-> (sts2[1] && sts2[2])); // R5
   AST_REBOOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reboot_pulse |=> !reboot_pulse); // R5
   AST_START_NEEDS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(tmr > 16'd1)); // R2
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock) |-> lock); // R8
endmodule

bind wdog_top wdog_chk u_chk (
   .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .no_reboot(no_reboot),
   .reboot_pulse(reboot_pulse), .run(run_w), .lock(lock_w),
   .tmr(tmr_w), .sts2(sts2_w)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
   timeunit 1ns; timeprecision 100ps;

   localparam int T = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        strap_hi = 1'b0, no_reboot = 1'b0, smi_en = 1'b0;
   logic        smi_pulse, reboot_pulse;

   int     n_chk = 0, n_fail = 0;
   longint cyc = 0;
   longint last_wr = 0;

   typedef struct {int kind; longint at; string req;} ev_t;
   ev_t evq[$];

   wdog_top #(.TICK_CYCLES(T), .CNT_W(10)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .strap_hi(strap_hi), .no_reboot(no_reboot), .smi_en(smi_en),
      .smi_pulse(smi_pulse), .reboot_pulse(reboot_pulse)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compares pulses against the expected-event queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (evq.size() > 0 && evq[0].at < cyc) begin
            ev_t m;
            m = evq.pop_front();
            n_chk++; n_fail++;
            $display("FAIL %s: missing pulse kind %0d, actual none, expected at cycle %0d", m.req, m.kind, m.at);
         end
         if (smi_pulse || reboot_pulse) begin
            int k;
            k = reboot_pulse ? 2 : 1;
            n_chk++;
            if (evq.size() == 0) begin
               n_fail++;
               $display("FAIL R4/R11: unexpected pulse kind %0d at cycle %0d, expected none", k, cyc);
            end else begin
               ev_t e;
               e = evq.pop_front();
               if (e.kind != k || e.at != cyc) begin
                  n_fail++;
                  $display("FAIL %s: pulse kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                           e.req, k, cyc, e.kind, e.at);
               end
            end
         end
      end
   end

   task automatic push(input int kind, input longint at, input string req);
      ev_t e;
      e.kind = kind; e.at = at; e.req = req;
      evq.push_back(e);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
      last_wr = cyc;
   endtask

   task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string req);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      n_chk++;
      if (bus_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s: addr 0x%02h actual 0x%04h expected 0x%04h", req, a, bus_rdata, exp);
      end
      bus_sel = 1'b0;
   endtask

   task automatic wait_until(input longint c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic queue_empty(input string req);
      n_chk++;
      if (evq.size() != 0) begin
         n_fail++;
         $display("FAIL %s: actual %0d pending pulses, expected 0", req, evq.size());
      end
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      longint w, w2, w3;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd(5'h12, 16'h0004, "R1");
      rd(5'h0A, 16'h0008, "R1");
      rd(5'h10, 16'h0003, "R1");
      rd(5'h00, 16'h0000, "R1");
      rd(5'h04, 16'h0000, "R1");
      rd(5'h06, 16'h0000, "R1");
      rd(5'h08, 16'h0000, "R1");
      repeat (20) @(negedge clk);

      // R11: first expiry with smi_en low gives no pulse; R6: blocked second expiry
      strap_hi = 1'b1; smi_en = 1'b0;
      wr(5'h08, 16'h0000);
      w = last_wr;
      wait_until(w + 40);
      rd(5'h04, 16'h0008, "R4 R11");
      smi_en = 1'b1;
      push(1, w + 4*T*2, "R6");
      push(1, w + 4*T*3, "R4");
      wait_until(w + 70);
      rd(5'h06, 16'h0006, "R6");
      wait_until(w + 100);
      wr(5'h08, 16'h0800);           // R2 halt stops the countdown
      rd(5'h08, 16'h0800, "R2");
      wait_until(w + 240);
      queue_empty("R2");

      // R9 status masks
      wr(5'h04, 16'hFFFF);
      rd(5'h04, 16'hE870, "R9");
      wr(5'h06, 16'hFFFF);
      rd(5'h06, 16'hFFF8, "R9");
      wr(5'h04, 16'h0000);
      wr(5'h06, 16'h0000);

      // R10 remaining ticks, R3 count clearing, R5 reboot
      strap_hi = 1'b0; no_reboot = 1'b0;
      wr(5'h12, 16'h000A);
      wr(5'h08, 16'h0000);
      w = last_wr;
      wait_until(w + 19);
      rd(5'h00, 16'h0008, "R10");
      wr(5'h00, 16'h0000);
      w2 = last_wr;
      push(1, w2 + 10*T, "R4");
      wait_until(w2 + 100);
      wr(5'h00, 16'h0000);
      w3 = last_wr;
      push(1, w3 + 10*T, "R3");
      push(2, w3 + 20*T, "R5");
      wait_until(w3 + 170);
      rd(5'h00, 16'h0000, "R5");
      rd(5'h06, 16'h0006, "R5");
      rd(5'h04, 16'h0008, "R4");
      wait_until(w3 + 400);
      queue_empty("R5");

      // R2 initial value 1 refused; R3 stores written value
      wr(5'h12, 16'h0001);
      wr(5'h00, 16'h0155);
      rd(5'h00, 16'h0155, "R3");
      wr(5'h08, 16'h0000);
      w = last_wr;
      wait_until(w + 100);
      rd(5'h00, 16'h0155, "R2");
      queue_empty("R2");

      // R7 data-in / data-out
      wr(5'h04, 16'h0000);
      smi_en = 1'b0;
      wr(5'h02, 16'h00A5);
      push(1, last_wr, "R7");
      rd(5'h04, 16'h0002, "R7");
      rd(5'h02, 16'h00A5, "R7");
      wr(5'h03, 16'h005A);
      rd(5'h04, 16'h0006, "R7");
      rd(5'h03, 16'h005A, "R7");
      repeat (5) @(negedge clk);
      queue_empty("R7");

      // R8 control1 mask and sticky lock
      wr(5'h08, 16'hFFFF);
      rd(5'h08, 16'hFEFF, "R8");
      wr(5'h08, 16'h0000);
      rd(5'h08, 16'h1000, "R8");
      repeat (50) @(negedge clk);
      queue_empty("R8");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule